// File: doc/BRIEF.md
# Cascadable Four-Lane Multiply-Add Slice

This block multiplies four pairs of signed operands and reduces the products to one sum. It does this in two steps. Two pair units each add two products. A final adder then joins the two pair results. The sum then enters an accumulator stage, which adds or subtracts it into a wide running total. A signed link input from a neighbouring slice can be added to that total. The result leaves on the `result` port and, unchanged, on a link output, so slices can be placed in a row to build wide dot products or filter taps.

There are three register stages, each with its own static enable:
- operand,
- pair-sum,
- output.

The add/subtract and clear controls travel through the same stages as the operands they belong to. A static tap mode turns the operand registers of the `a` side into a shift line. Lane 0 feeds that line, so each multiplier sees the sample one clock older than its neighbour, which suits a single-channel FIR filter. A synchronous reset clears every register. A shared clock enable stalls all registers together.

Top module: `dsp_quad_mac`

## Requirements
- R1: With every stage bypassed and accumulation off, `result` equals a0*b0 + a1*b1 + a2*b2 + a3*b3, sign-extended to ACCW bits. Operand lane k occupies bits [k*OPW +: OPW] of `a_in` and `b_in`, all in two's complement.
- R2: Each pair unit keeps the full 2*OPW+1 bit sum of its two products, and the final sum is 2*OPW+2 bits. Full-scale operands (all +131071, or all -131072) therefore give exact results with no wrap.
- R3: `sub` = 1 subtracts the product sum instead of adding it. With accumulation off the result is the negated sum.
- R4: With `cfg_accum` = 1 and `acc_clr` = 0, each enabled clock loads the output register with its previous value plus or minus the current sum.
- R5: `acc_clr` = 1 loads the current signed sum, plus the link input when linking is on, in place of the feedback value.
- R6: With `cfg_chain` = 1, `chain_in` is added to the slice total. With `cfg_chain` = 0, `chain_in` has no effect. `chain_out` always equals `result`.
- R7: The operand, pair and output stages can each be bypassed by their own bit. The latency from inputs to `result` equals the number of stages enabled.
- R8: `sub` and `acc_clr` pass through the same enabled stages as the operands, so each applies to the data that was presented with it.
- R9: In tap mode the `a` operand registers form a shift line fed from lane 0, and multiplier k sees the lane-0 sample from k+1 enabled clocks earlier. The `a` inputs of lanes 1 to 3 are then ignored, and the `b` operands follow `cfg_in_reg` as usual.
- R10: While `ce` = 0 no register changes, so with the output stage enabled `result` holds.
- R11: A synchronous `rst` clears every register, including the accumulator and the tap line, to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all registers |
| cfg_in_reg | input | 1 | Static: use the operand register stage |
| cfg_pipe_reg | input | 1 | Static: use the pair-sum register stage |
| cfg_out_reg | input | 1 | Static: drive the outputs from the output register |
| cfg_tap | input | 1 | Static: `a` operand registers form a shift line fed from lane 0 |
| cfg_accum | input | 1 | Static: feed the output register back into the adder |
| cfg_chain | input | 1 | Static: add `chain_in` into the total |
| a_in | input | NMUL*OPW | Signed `a` operands, lane k at [k*OPW +: OPW] |
| b_in | input | NMUL*OPW | Signed `b` operands, lane k at [k*OPW +: OPW] |
| sub | input | 1 | 1 = subtract the product sum, 0 = add it |
| acc_clr | input | 1 | Load the sum in place of the feedback value |
| chain_in | input | ACCW | Signed total from the preceding slice |
| result | output | ACCW | Signed slice result |
| chain_out | output | ACCW | Copy of `result` for the next slice |

## Verification
The bench builds the slice with its defaults: 18-bit operands, four lanes and a 44-bit total. At these widths the extreme products 131071 squared and -131072 squared can be checked as exact constants, and a wrap in the 37- or 38-bit partial sums would be visible. The configuration bits are changed between tests and not by parameter. This lets one build cover fully combinational operation, one- and three-stage latency, a three-deep controlled stream, and the four-lane tap line with its ignored side lanes.

// File: rtl/dsp_quad_pkg.sv
package dsp_quad_pkg;
  localparam int DEF_OPW  = 18;
  localparam int DEF_NMUL = 4;
  localparam int DEF_ACCW = 44;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } sign_op_e;
endpackage

// File: rtl/dsp_pipe_reg.sv
module dsp_pipe_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] r;

  always_ff @(posedge clk) begin
    if (rst)     r <= '0;
    else if (ce) r <= d;
  end

  assign q = en ? r : d;
endmodule

// File: rtl/dsp_operand_stage.sv
module dsp_operand_stage #(
  parameter int OPW  = 18,
  parameter int NMUL = 4,
  localparam int VW  = OPW * NMUL
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          use_reg,
  input  logic          tap_en,
  input  logic [VW-1:0] a_in,
  input  logic [VW-1:0] b_in,
  output logic [VW-1:0] a_use,
  output logic [VW-1:0] b_use,
  output logic [VW-1:0] tap_q
);
  logic [OPW-1:0] a_q [NMUL];
  logic [OPW-1:0] a_d [NMUL];
  logic [VW-1:0]  b_q;

  // Lane 0 always loads its own input; other lanes load the previous
  // lane's register in tap mode to form the delay line.
  for (genvar i = 0; i < NMUL; i++) begin : g_lane
    if (i == 0) begin : g_head
      assign a_d[i] = a_in[OPW-1:0];
    end else begin : g_link
      assign a_d[i] = tap_en ? a_q[i-1] : a_in[i*OPW +: OPW];
    end
    assign a_use[i*OPW +: OPW] = (use_reg || tap_en) ? a_q[i] : a_in[i*OPW +: OPW];
    assign tap_q[i*OPW +: OPW] = a_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NMUL; i++) a_q[i] <= '0;
      b_q <= '0;
    end else if (ce) begin
      for (int i = 0; i < NMUL; i++) a_q[i] <= a_d[i];
      b_q <= b_in;
    end
  end

  assign b_use = use_reg ? b_q : b_in;
endmodule

// File: rtl/dsp_pair_mult.sv
module dsp_pair_mult #(
  parameter int OPW = 18,
  localparam int PW = 2 * OPW + 1
) (
  input  logic signed [OPW-1:0] x0,
  input  logic signed [OPW-1:0] y0,
  input  logic signed [OPW-1:0] x1,
  input  logic signed [OPW-1:0] y1,
  output logic signed [PW-1:0]  psum
);
  // Two full products, each sign-extended by one bit before the add.
  function automatic logic signed [PW-1:0] mul_pair(
    input logic signed [OPW-1:0] p, input logic signed [OPW-1:0] q,
    input logic signed [OPW-1:0] r, input logic signed [OPW-1:0] s);
    logic signed [2*OPW-1:0] m0, m1;
    m0 = p * q;
    m1 = r * s;
    return PW'(m0) + PW'(m1);
  endfunction

  assign psum = mul_pair(x0, y0, x1, y1);
endmodule

// File: rtl/dsp_accum.sv
module dsp_accum
  import dsp_quad_pkg::*;
#(
  parameter int SW   = 38,
  parameter int ACCW = 44
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ce,
  input  logic                   out_reg,
  input  logic                   acc_on,
  input  logic                   chain_on,
  input  logic                   sub,
  input  logic                   clr,
  input  logic signed [SW-1:0]   sum,
  input  logic signed [ACCW-1:0] chain_in,
  output logic signed [ACCW-1:0] acc_q,
  output logic signed [ACCW-1:0] result
);
  logic signed [ACCW-1:0] total;

  function automatic logic signed [ACCW-1:0] next_total(
    input logic signed [ACCW-1:0] fb, input logic signed [SW-1:0] s,
    input sign_op_e op, input logic load, input logic fb_on,
    input logic link_on, input logic signed [ACCW-1:0] link);
    logic signed [ACCW-1:0] base, term, extra;
    base  = (fb_on && !load) ? fb : '0;
    term  = ACCW'(s);
    if (op == OP_SUB) term = -term;
    extra = link_on ? link : '0;
    return base + term + extra;
  endfunction

  assign total = next_total(acc_q, sum, sign_op_e'(sub), clr, acc_on, chain_on, chain_in);

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (ce) acc_q <= total;
  end

  assign result = out_reg ? acc_q : total;
endmodule

// File: rtl/dsp_quad_mac.sv
module dsp_quad_mac
  import dsp_quad_pkg::*;
#(
  parameter int OPW  = DEF_OPW,
  parameter int NMUL = DEF_NMUL,
  parameter int ACCW = DEF_ACCW,
  localparam int VW    = OPW * NMUL,
  localparam int NPAIR = NMUL / 2,
  localparam int PW    = 2 * OPW + 1,
  localparam int SW    = PW + $clog2(NPAIR),
  localparam int PVW   = PW * NPAIR
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ce,
  input  logic                   cfg_in_reg,
  input  logic                   cfg_pipe_reg,
  input  logic                   cfg_out_reg,
  input  logic                   cfg_tap,
  input  logic                   cfg_accum,
  input  logic                   cfg_chain,
  input  logic [VW-1:0]          a_in,
  input  logic [VW-1:0]          b_in,
  input  logic                   sub,
  input  logic                   acc_clr,
  input  logic signed [ACCW-1:0] chain_in,
  output logic signed [ACCW-1:0] result,
  output logic signed [ACCW-1:0] chain_out
);
  logic [VW-1:0]        a_use, b_use, tap_q;
  logic [1:0]           ctl_s2;
  logic [PVW-1:0]       pair_s2, pair_s3;
  logic                 sub_s3, clr_s3;
  logic signed [SW-1:0] sum_s3;
  logic signed [ACCW-1:0] acc_q;

  // Stage 1: operands (with optional tap line) and their controls.
  dsp_operand_stage #(.OPW(OPW), .NMUL(NMUL)) u_ops (
    .clk(clk), .rst(rst), .ce(ce), .use_reg(cfg_in_reg), .tap_en(cfg_tap),
    .a_in(a_in), .b_in(b_in), .a_use(a_use), .b_use(b_use), .tap_q(tap_q)
  );

  dsp_pipe_reg #(.W(2)) u_ctl1 (
    .clk(clk), .rst(rst), .ce(ce), .en(cfg_in_reg),
    .d({sub, acc_clr}), .q(ctl_s2)
  );

  // Pair multiply-add units.
  for (genvar j = 0; j < NPAIR; j++) begin : g_pair
    dsp_pair_mult #(.OPW(OPW)) u_pair (
      .x0(signed'(a_use[(2*j)*OPW +: OPW])),
      .y0(signed'(b_use[(2*j)*OPW +: OPW])),
      .x1(signed'(a_use[(2*j+1)*OPW +: OPW])),
      .y1(signed'(b_use[(2*j+1)*OPW +: OPW])),
      .psum(pair_s2[j*PW +: PW])
    );
  end

  // Stage 2: pair sums with their controls.
  dsp_pipe_reg #(.W(PVW + 2)) u_mid (
    .clk(clk), .rst(rst), .ce(ce), .en(cfg_pipe_reg),
    .d({ctl_s2, pair_s2}), .q({sub_s3, clr_s3, pair_s3})
  );

  // Final adder over all pair sums, each sign-extended.
  always_comb begin
    sum_s3 = '0;
    for (int j = 0; j < NPAIR; j++)
      sum_s3 = sum_s3 + SW'(signed'(pair_s3[j*PW +: PW]));
  end

  // Stage 3: accumulate / link / output register.
  dsp_accum #(.SW(SW), .ACCW(ACCW)) u_acc (
    .clk(clk), .rst(rst), .ce(ce), .out_reg(cfg_out_reg), .acc_on(cfg_accum),
    .chain_on(cfg_chain), .sub(sub_s3), .clr(clr_s3), .sum(sum_s3),
    .chain_in(chain_in), .acc_q(acc_q), .result(result)
  );

  assign chain_out = result;
endmodule

// File: rtl/dsp_quad_mac_chk.sv
module dsp_quad_mac_chk #(
  parameter int OPW  = 18,
  parameter int NMUL = 4,
  parameter int ACCW = 44,
  parameter int SW   = 38
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ce,
  input logic                   cfg_tap,
  input logic                   cfg_accum,
  input logic                   cfg_chain,
  input logic                   sub_s3,
  input logic                   clr_s3,
  input logic signed [SW-1:0]   sum_s3,
  input logic signed [ACCW-1:0] acc_q,
  input logic [OPW*NMUL-1:0]    tap_q
);
  function automatic logic signed [ACCW-1:0] signed_term(
    input logic neg, input logic signed [SW-1:0] s);
    logic signed [ACCW-1:0] t;
    t = ACCW'(s);
    return neg ? -t : t;
  endfunction

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && (tap_q == '0));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(acc_q) && $stable(tap_q));

  // R4 and R3: feedback plus or minus the aligned sum.
  p_accum_step_r4: assert property (@(posedge clk) disable iff (rst)
    (ce && cfg_accum && !clr_s3 && !cfg_chain) |=>
      acc_q == $past(acc_q) + signed_term($past(sub_s3), $past(sum_s3)));

  p_clear_load_r5: assert property (@(posedge clk) disable iff (rst)
    (ce && clr_s3 && !cfg_chain) |=>
      acc_q == signed_term($past(sub_s3), $past(sum_s3)));

  for (genvar k = 1; k < NMUL; k++) begin : g_tap
    p_tap_shift_r9: assert property (@(posedge clk) disable iff (rst)
      (ce && cfg_tap) |=>
        tap_q[k*OPW +: OPW] == $past(tap_q[(k-1)*OPW +: OPW]));
  end
endmodule

bind dsp_quad_mac dsp_quad_mac_chk #(
  .OPW(OPW), .NMUL(NMUL), .ACCW(ACCW), .SW(SW)
) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .cfg_tap(cfg_tap), .cfg_accum(cfg_accum),
  .cfg_chain(cfg_chain), .sub_s3(sub_s3), .clr_s3(clr_s3), .sum_s3(sum_s3),
  .acc_q(acc_q), .tap_q(tap_q)
);

// File: tb/dsp_quad_mac_tb.sv
`timescale 1ns/1ps
module dsp_quad_mac_tb;
  localparam int OPW = 18, NMUL = 4, ACCW = 44, NV = 6;

  logic clk = 1'b0;
  logic rst, ce, cfg_in_reg, cfg_pipe_reg, cfg_out_reg, cfg_tap, cfg_accum, cfg_chain;
  logic [OPW*NMUL-1:0] a_in, b_in;
  logic sub, acc_clr;
  logic signed [ACCW-1:0] chain_in, result, chain_out;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  dsp_quad_mac u_dut (
    .clk(clk), .rst(rst), .ce(ce), .cfg_in_reg(cfg_in_reg), .cfg_pipe_reg(cfg_pipe_reg),
    .cfg_out_reg(cfg_out_reg), .cfg_tap(cfg_tap), .cfg_accum(cfg_accum),
    .cfg_chain(cfg_chain), .a_in(a_in), .b_in(b_in), .sub(sub), .acc_clr(acc_clr),
    .chain_in(chain_in), .result(result), .chain_out(chain_out)
  );

  // Vectors for fully combinational mode with linking on.
  localparam logic signed [OPW-1:0] TA [NV][NMUL] = '{
    '{18'sd1, 18'sd2, 18'sd3, 18'sd4},
    '{18'sd1, 18'sd2, 18'sd3, 18'sd4},
    '{-18'sd3, 18'sd4, 18'sd0, 18'sd0},
    '{18'sd131071, 18'sd131071, 18'sd131071, 18'sd131071},
    '{18'h20000, 18'h20000, 18'h20000, 18'h20000},
    '{18'h20000, 18'sd0, 18'sd0, 18'sd0}};
  localparam logic signed [OPW-1:0] TB [NV][NMUL] = '{
    '{18'sd5, 18'sd6, 18'sd7, 18'sd8},
    '{18'sd5, 18'sd6, 18'sd7, 18'sd8},
    '{18'sd7, -18'sd2, 18'sd0, 18'sd0},
    '{18'sd131071, 18'sd131071, 18'sd131071, 18'sd131071},
    '{18'h20000, 18'h20000, 18'h20000, 18'h20000},
    '{18'sd131071, 18'sd0, 18'sd0, 18'sd0}};
  localparam logic TSUB [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic signed [ACCW-1:0] TCH [NV] = '{
    44'sd0, 44'sd0, 44'sd100, 44'sd0, 44'sd0, -44'sd5};
  localparam logic signed [ACCW-1:0] TEXP [NV] = '{
    44'sd70, -44'sd70, 44'sd71, 44'sd68718428164, -44'sd68719476736, -44'sd17179738117};

  task automatic check(input string tag, input logic signed [ACCW-1:0] act,
                       input logic signed [ACCW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input int a0, input int a1, input int a2, input int a3,
                     input int b0, input int b1, input int b2, input int b3);
    a_in = {OPW'(a3), OPW'(a2), OPW'(a1), OPW'(a0)};
    b_in = {OPW'(b3), OPW'(b2), OPW'(b1), OPW'(b0)};
  endtask

  task automatic cfg(input logic ir, input logic pr, input logic orr, input logic tp,
                     input logic ac, input logic ch);
    @(negedge clk);
    cfg_in_reg = ir; cfg_pipe_reg = pr; cfg_out_reg = orr;
    cfg_tap = tp; cfg_accum = ac; cfg_chain = ch;
    rst = 1'b1; ce = 1'b1; sub = 1'b0; acc_clr = 1'b0; chain_in = '0;
    put(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1; ce = 1'b0; sub = 1'b0; acc_clr = 1'b0; chain_in = '0;
    cfg_in_reg = 1'b1; cfg_pipe_reg = 1'b1; cfg_out_reg = 1'b1;
    cfg_tap = 1'b0; cfg_accum = 1'b1; cfg_chain = 1'b0;
    put(9, 9, 9, 9, 9, 9, 9, 9);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 result after reset", result, 0);
    check("R11 chain_out after reset", chain_out, 0);

    // Table walk: R1, R2, R3, R6 in combinational mode.
    cfg(0, 0, 0, 0, 0, 1);
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      a_in = {TA[v][3], TA[v][2], TA[v][1], TA[v][0]};
      b_in = {TB[v][3], TB[v][2], TB[v][1], TB[v][0]};
      sub = TSUB[v]; chain_in = TCH[v];
      #1;
      check($sformatf("R1/R2/R3 vector %0d", v), result, TEXP[v]);
      check($sformatf("R6 chain_out vector %0d", v), chain_out, TEXP[v]);
    end

    // R6: link input ignored when linking is off.
    cfg(0, 0, 0, 0, 0, 0);
    @(negedge clk); put(1, 2, 3, 4, 5, 6, 7, 8); chain_in = 44'sd1000; #1;
    check("R6 chain_in ignored", result, 70);

    // R7: three stages give three clocks of latency.
    cfg(1, 1, 1, 0, 0, 0);
    put(1, 2, 3, 4, 5, 6, 7, 8);
    @(negedge clk); put(0, 0, 0, 0, 0, 0, 0, 0);
    check("R7 full pipe edge1", result, 0);
    @(negedge clk); check("R7 full pipe edge2", result, 0);
    @(negedge clk); check("R7 full pipe edge3", result, 70);
    @(negedge clk); check("R7 full pipe edge4", result, 0);

    // R7: only the pair stage, one clock of latency.
    cfg(0, 1, 0, 0, 0, 0);
    put(1, 2, 3, 4, 5, 6, 7, 8); #1;
    check("R7 pair stage before edge", result, 0);
    @(negedge clk); check("R7 pair stage after edge", result, 70);

    // R4, R5, R3: accumulate with the output stage only.
    cfg(0, 0, 1, 0, 1, 0);
    put(1, 2, 3, 4, 5, 6, 7, 8); acc_clr = 1'b1;
    @(negedge clk); check("R5 clear loads sum", result, 70); acc_clr = 1'b0;
    @(negedge clk); check("R4 add step", result, 140); sub = 1'b1;
    @(negedge clk); check("R3 subtract step", result, 70);
    @(negedge clk); check("R3 subtract to zero", result, 0);
    @(negedge clk); check("R3 subtract below zero", result, -70);

    // R8: controls stay aligned with data through three stages.
    cfg(1, 1, 1, 0, 1, 0);
    put(1, 2, 3, 4, 5, 6, 7, 8); acc_clr = 1'b1; sub = 1'b0;
    @(negedge clk); put(10, 0, 0, 0, 1, 0, 0, 0); acc_clr = 1'b0; sub = 1'b1;
    @(negedge clk); put(5, 0, 0, 0, 1, 0, 0, 0); sub = 1'b0;
    @(negedge clk); put(0, 0, 0, 0, 0, 0, 0, 0);
    check("R8 clear aligned", result, 70);
    @(negedge clk); check("R8 subtract aligned", result, 60);
    @(negedge clk); check("R8 add aligned", result, 65);
    @(negedge clk); check("R8 zero input holds", result, 65);

    // R10: stall.
    put(1, 2, 3, 4, 5, 6, 7, 8); ce = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 stalled result", result, 65);
    ce = 1'b1;

    // R9: tap line, lanes 1..3 of a driven with junk that must be ignored.
    cfg(1, 0, 0, 1, 0, 0);
    put(1, 77, 77, 77, 1, 10, 100, 1000);
    @(negedge clk); check("R9 tap step1", result, 1);
    put(2, 77, 77, 77, 1, 10, 100, 1000);
    @(negedge clk); check("R9 tap step2", result, 12);
    put(3, 77, 77, 77, 1, 10, 100, 1000);
    @(negedge clk); check("R9 tap step3", result, 123);
    put(4, 77, 77, 77, 1, 10, 100, 1000);
    @(negedge clk); check("R9 tap step4", result, 1234);
    put(0, 77, 77, 77, 1, 10, 100, 1000);
    @(negedge clk); check("R9 tap step5", result, 2340);

    // R11: reset clears accumulator mid-run.
    cfg(0, 0, 1, 0, 1, 0);
    put(1, 2, 3, 4, 5, 6, 7, 8);
    @(negedge clk); check("R11 pre-reset accum", result, 70);
    rst = 1'b1;
    @(negedge clk); check("R11 reset clears accum", result, 0);
    rst = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule